// File: doc/BRIEF.md
# Prescaled Edge Input Capture

This block timestamps events on a single capture input. Whenever the selected edge condition occurs, it copies the free-running timer value into a four-entry first-in first-out buffer. Software or a neighbouring block drains that buffer one word per read strobe. The edge qualifier can take every edge, only rising edges, only falling edges, or a prescaled count of rising edges: every fourth or every sixteenth.

A six-bit configuration word selects the behaviour. Bit 5 chooses between capturing the full 32-bit timer value and capturing only its low 16 bits. Bit 4 enables capture operation. Bits 3..0 hold the edge code. The capture input is expected to be synchronized to the clock already. An enable input turns the unit off. While the unit is off, the buffer and the overflow flag are cleared and the edge prescaler is held at zero.

Top module: `cap_unit`

## Requirements
- R1: After reset, notEmpty, overflow and capPulse are 0 and rdData is 0.
- R2: With edge code 1, a capture happens on each rising edge of capIn and on no falling edge.
- R3: With edge code 2, a capture happens on each falling edge of capIn and on no rising edge.
- R4: With edge code 0 or edge code 3, every rising edge and every falling edge of capIn is captured.
- R5: With edge code 4, only every 4th rising edge is captured, counted from the last clear of the prescaler.
- R6: With edge code 5, only every 16th rising edge is captured.
- R7: When modeCfg bit 5 is 1, all 32 timer bits are stored. When it is 0, the stored word carries timerVal[15:0] with the upper 16 bits zero.
- R8: No capture happens while enable is 0, while modeCfg bit 4 is 0, or when the edge code is 6 to 15.
- R9: The buffer holds four entries in arrival order. A read strobe on a non-empty buffer puts the oldest entry on rdData one clock later, and notEmpty is 1 exactly while entries are waiting.
- R10: A capture that arrives when four entries are held, with no read in the same cycle, is discarded and sets overflow. Overflow stays set until enable goes low, and enable low also empties the buffer.
- R11: A read strobe on an empty buffer leaves rdData at the last value read and changes neither notEmpty nor overflow.
- R12: The rising-edge prescaler returns to zero whenever modeCfg changes or enable is 0.
- R13: capPulse is high for exactly one cycle, the clock after each qualifying edge, including a capture that is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Unit enable; low flushes the buffer, clears overflow and clears the prescaler |
| capIn | input | 1 | Synchronized capture input |
| timerVal | input | 32 | Current timer value |
| modeCfg | input | 6 | [5] full-width select, [4] capture select, [3:0] edge code |
| rdStrobe | input | 1 | Pop the oldest buffered value |
| rdData | output | 32 | Last value popped from the buffer |
| notEmpty | output | 1 | At least one capture is waiting |
| overflow | output | 1 | Sticky flag for a discarded capture |
| capPulse | output | 1 | One-cycle pulse for each qualifying edge |

## Verification
An edge driven onto capIn is seen at the next rising clock. That edge writes the timer value present there into the buffer, so capPulse, notEmpty and overflow all show the result one clock after the input changed. A read strobe updates rdData and the flags at the same single-clock latency. The bench changes inputs only on falling edges and samples at the falling edge one full cycle later, so each result is checked in the exact cycle it is due. The driver task pushes each expected capture into a model queue. The read task pops that queue and compares it against rdData, so ordering, discards and width masking are checked against a model that never looks at the design's internals.

// File: rtl/cap_pkg.sv
package cap_pkg;

  // Edge codes carried in modeCfg[3:0]
  typedef enum logic [3:0] {
    EDGE_ANY    = 4'd0,
    EDGE_RISE   = 4'd1,
    EDGE_FALL   = 4'd2,
    EDGE_BOTH   = 4'd3,
    EDGE_RISE4  = 4'd4,
    EDGE_RISE16 = 4'd5
  } edgeCode_e;

  // Bit positions inside the configuration word
  localparam int CFG_WIDE_BIT = 5;
  localparam int CFG_SEL_BIT  = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;   // store the current timer value
    logic flush;  // empty buffer, clear overflow
  } capStrobe_t;

endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int PRE_FEW  = 4,
  parameter int PRE_MANY = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       capIn,
  input  logic [5:0] modeCfg,
  output capStrobe_t strobe,
  output logic       capPulse
);

  localparam int CW = $clog2(PRE_MANY);
  localparam logic [CW-1:0] FEW_LAST  = CW'(PRE_FEW - 1);
  localparam logic [CW-1:0] MANY_LAST = CW'(PRE_MANY - 1);

  logic          prevIn;
  logic [5:0]    lastMode;
  logic [CW-1:0] riseCnt;
  logic          rise, fall, active, modeChange, qualify, prescaled;
  logic [CW-1:0] cntLast;
  logic [3:0]    code;

  assign code       = modeCfg[3:0];
  assign rise       = capIn & ~prevIn;
  assign fall       = ~capIn & prevIn;
  assign active     = enable & modeCfg[CFG_SEL_BIT];
  assign modeChange = (modeCfg != lastMode);
  assign prescaled  = (code == EDGE_RISE4) || (code == EDGE_RISE16);
  assign cntLast    = (code == EDGE_RISE4) ? FEW_LAST : MANY_LAST;

  always_comb begin
    case (code)
      EDGE_ANY, EDGE_BOTH:     qualify = rise | fall;
      EDGE_RISE:               qualify = rise;
      EDGE_FALL:               qualify = fall;
      EDGE_RISE4, EDGE_RISE16: qualify = rise && (riseCnt == cntLast);
      default:                 qualify = 1'b0;
    endcase
  end

  assign strobe.push  = active & ~modeChange & qualify;
  assign strobe.flush = ~enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn   <= 1'b0;
      lastMode <= '0;
      riseCnt  <= '0;
      capPulse <= 1'b0;
    end else begin
      prevIn   <= capIn;
      lastMode <= modeCfg;
      capPulse <= strobe.push;
      if (!enable || modeChange) begin
        riseCnt <= '0;
      end else if (active && prescaled && rise) begin
        riseCnt <= (riseCnt == cntLast) ? '0 : riseCnt + 1'b1;
      end
    end
  end

  // R8: nothing is captured while the unit is inactive
  a_r8_no_push_idle: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !strobe.push);

  // R2: a rising-only capture needs the input high
  a_r2_rise_level: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && code == EDGE_RISE) |-> capIn);

  // R3: a falling-only capture needs the input low
  a_r3_fall_level: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && code == EDGE_FALL) |-> !capIn);

  // R12: the prescaler is zero the cycle after a mode change
  a_r12_cnt_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (modeChange || !enable) |=> (riseCnt == '0));

endmodule

// File: rtl/cap_dp.sv
module cap_dp
  import cap_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strobe,
  input  logic             wide,
  input  logic [WIDTH-1:0] capVal,
  input  logic             rdStrobe,
  output logic [WIDTH-1:0] rdData,
  output logic             notEmpty,
  output logic             overflow
);

  localparam int HALF = WIDTH / 2;
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic [WIDTH-1:0] capWord;
  logic             full, pop, accept;

  assign capWord  = wide ? capVal : {{(WIDTH-HALF){1'b0}}, capVal[HALF-1:0]};
  assign full     = (count == FULL_CNT);
  assign pop      = rdStrobe && (count != '0);
  assign accept   = strobe.push && (!full || pop);
  assign notEmpty = (count != '0);

  always_ff @(posedge clk) begin
    if (accept && !strobe.flush) mem[wrPtr] <= capWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
      rdData   <= '0;
    end else if (strobe.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (pop) begin
        rdData <= mem[rdPtr];
        rdPtr  <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      end
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (strobe.push && !accept) overflow <= 1'b1;
    end
  end

  // R9: occupancy never exceeds the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R10: overflow stays set until a flush
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strobe.flush) |=> overflow);

  // R10: overflow only rises after a capture request
  a_r10_ovf_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(strobe.push));

  // R11: a read of an empty buffer leaves the read data alone
  a_r11_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !notEmpty) |=> $stable(rdData));

endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        capIn,
  input  logic [31:0] timerVal,
  input  logic [5:0]  modeCfg,
  input  logic        rdStrobe,
  output logic [31:0] rdData,
  output logic        notEmpty,
  output logic        overflow,
  output logic        capPulse
);

  capStrobe_t strobe;

  cap_ctrl #(.PRE_FEW(4), .PRE_MANY(16)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .capIn    (capIn),
    .modeCfg  (modeCfg),
    .strobe   (strobe),
    .capPulse (capPulse)
  );

  cap_dp #(.WIDTH(32), .DEPTH(4)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wide     (modeCfg[CFG_WIDE_BIT]),
    .capVal   (timerVal),
    .rdStrobe (rdStrobe),
    .rdData   (rdData),
    .notEmpty (notEmpty),
    .overflow (overflow)
  );

  // R13: each pulse follows a capture request
  a_r13_pulse_src: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capPulse) |-> $past(strobe.push));

endmodule

// File: tb/cap_unit_bench.sv
module cap_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN, enable, capIn, rdStrobe;
  logic [31:0] timerVal;
  logic [5:0]  modeCfg;
  logic [31:0] rdData;
  logic        notEmpty, overflow, capPulse;

  cap_unit u_cap_unit (
    .clk(clk), .rstN(rstN), .enable(enable), .capIn(capIn),
    .timerVal(timerVal), .modeCfg(modeCfg), .rdStrobe(rdStrobe),
    .rdData(rdData), .notEmpty(notEmpty), .overflow(overflow),
    .capPulse(capPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          total = 0;
  int          bad = 0;
  logic [31:0] expQ [$];
  logic        expOvf = 1'b0;
  logic [31:0] lastRead = '0;
  bit          wideNow = 1'b0;
  bit          done = 1'b0;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic flags(input string req);
    chk(notEmpty == (expQ.size() > 0), req, 32'(notEmpty), 32'(expQ.size() > 0));
    chk(overflow == expOvf, req, 32'(overflow), 32'(expOvf));
  endtask

  // Driver: change the input, then check the result one clock later
  task automatic drive(input logic lvl, input logic [31:0] tv,
                       input bit qual, input string req);
    @(negedge clk);
    capIn    = lvl;
    timerVal = tv;
    @(negedge clk);
    chk(capPulse == qual, req, 32'(capPulse), 32'(qual));
    if (qual) begin
      if (expQ.size() < 4) expQ.push_back(wideNow ? tv : {16'h0, tv[15:0]});
      else expOvf = 1'b1;
    end
    flags(req);
  endtask

  // Monitor side of the scoreboard: pop and compare
  task automatic readOne(input string req);
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    if (expQ.size() > 0) lastRead = expQ.pop_front();
    chk(rdData == lastRead, req, rdData, lastRead);
    flags(req);
  endtask

  task automatic setMode(input logic [5:0] m);
    @(negedge clk);
    modeCfg = m;
    wideNow = m[5];
    @(negedge clk);
  endtask

  task automatic pulseEnableLow(input string req);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    expQ.delete();
    expOvf = 1'b0;
    flags(req);
    enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; enable = 1'b0; capIn = 1'b0; rdStrobe = 1'b0;
    timerVal = '0; modeCfg = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rdData == 0, "R1", rdData, 0);
    chk(!notEmpty, "R1", 32'(notEmpty), 0);
    chk(!overflow, "R1", 32'(overflow), 0);
    chk(!capPulse, "R1", 32'(capPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    enable = 1'b1;

    // R2 rising only, narrow (R7 masking)
    setMode(6'h11);
    drive(1'b1, 32'hABCD_1234, 1'b1, "R2");
    @(negedge clk);
    chk(!capPulse, "R13", 32'(capPulse), 0);
    drive(1'b0, 32'h0000_2222, 1'b0, "R2");
    drive(1'b1, 32'h7777_5555, 1'b1, "R2");
    readOne("R7");
    readOne("R9");

    // R7 wide capture
    setMode(6'h31);
    drive(1'b0, 32'h0, 1'b0, "R7");
    drive(1'b1, 32'hDEAD_BEEF, 1'b1, "R7");
    readOne("R7");

    // R3 falling only
    setMode(6'h12);
    drive(1'b0, 32'h1111_0042, 1'b1, "R3");
    drive(1'b1, 32'h1111_0043, 1'b0, "R3");
    drive(1'b0, 32'h1111_0044, 1'b1, "R3");
    readOne("R3");
    readOne("R3");

    // R4 every edge (code 0 and code 3), fill to four
    setMode(6'h10);
    drive(1'b1, 32'h0000_0101, 1'b1, "R4");
    drive(1'b0, 32'h0000_0102, 1'b1, "R4");
    setMode(6'h13);
    drive(1'b1, 32'h0000_0103, 1'b1, "R4");
    drive(1'b0, 32'h0000_0104, 1'b1, "R4");
    // R10 two discarded captures
    setMode(6'h10);
    drive(1'b1, 32'h0000_0105, 1'b1, "R10");
    drive(1'b0, 32'h0000_0106, 1'b1, "R10");
    for (int i = 0; i < 4; i++) readOne("R9");
    // R11 read while empty
    readOne("R11");
    readOne("R11");
    pulseEnableLow("R10");

    // R8 capture select off, unused code, unit disabled
    setMode(6'h01);
    drive(1'b1, 32'h5, 1'b0, "R8");
    drive(1'b0, 32'h6, 1'b0, "R8");
    setMode(6'h17);
    drive(1'b1, 32'h7, 1'b0, "R8");
    drive(1'b0, 32'h8, 1'b0, "R8");
    setMode(6'h11);
    @(negedge clk);
    enable = 1'b0;
    drive(1'b1, 32'h9, 1'b0, "R8");
    drive(1'b0, 32'hA, 1'b0, "R8");
    enable = 1'b1;
    @(negedge clk);

    // R5 every fourth rising edge
    setMode(6'h14);
    for (int i = 1; i <= 8; i++) begin
      drive(1'b1, 32'(i * 3 + 7), (i % 4) == 0, "R5");
      drive(1'b0, 32'h0, 1'b0, "R5");
    end
    readOne("R5");
    readOne("R5");

    // R6 every sixteenth rising edge
    setMode(6'h35);
    for (int i = 1; i <= 16; i++) begin
      drive(1'b1, 32'h1000_0000 + 32'(i), i == 16, "R6");
      drive(1'b0, 32'h0, 1'b0, "R6");
    end
    readOne("R6");

    // R12 mode change clears the prescaler
    setMode(6'h14);
    for (int i = 1; i <= 2; i++) begin
      drive(1'b1, 32'h40 + 32'(i), 1'b0, "R12");
      drive(1'b0, 32'h0, 1'b0, "R12");
    end
    setMode(6'h15);
    setMode(6'h14);
    for (int i = 1; i <= 4; i++) begin
      drive(1'b1, 32'h50 + 32'(i), i == 4, "R12");
      drive(1'b0, 32'h0, 1'b0, "R12");
    end
    readOne("R12");
    // R12 disable clears the prescaler
    for (int i = 1; i <= 3; i++) begin
      drive(1'b1, 32'h60 + 32'(i), 1'b0, "R12");
      drive(1'b0, 32'h0, 1'b0, "R12");
    end
    pulseEnableLow("R12");
    for (int i = 1; i <= 4; i++) begin
      drive(1'b1, 32'h70 + 32'(i), i == 4, "R12");
      drive(1'b0, 32'h0, 1'b0, "R12");
    end
    readOne("R12");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule